// File: doc/BRIEF.md
# Controller Interrupt Acceptance and Trap Entry

This block sits between a core-local interrupt controller and the hart's trap logic. The controller offers one pending interrupt at a time as a flag and a packed 22-bit code. The code carries the privilege mode that should take the interrupt, its level, and its identifier. From the current privilege and the global enables, the block decides whether the hart takes the interrupt now.

When the hart takes the interrupt, the block registers a complete set of write-backs in one cycle. The set holds a cause word that packs the identifier with the prior level, prior enable and prior privilege. It also holds the new level for the target mode's level field, the exception PC, the new privilege, and a tagged internal exception code. The block then raises a request for the vector stage to compute the trap target. Until that stage acknowledges the request, no further interrupt is accepted. The surrounding CSR file applies the write-backs on the commit strobe, and the controller drops its pending flag on the same strobe.

Top module: `clic_trap_entry`

## Requirements
- R1: The code is split as identifier = bits [11:0], target mode = bits [13:12] (0 user, 1 supervisor, 3 machine), level = bits [21:14]. On commit, `tgt_id`, `tgt_mode` and `lvl_val` carry these fields.
- R2: A machine-target interrupt is accepted when `cur_priv` is below 3, or when `cur_priv` is 3 and `st_mie` is 1.
- R3: A supervisor-target interrupt is accepted when `cur_priv` is 0, or when `cur_priv` is 1 and `st_sie` is 1. Target modes 0 and 2 are never accepted, and a rejected interrupt produces no commit and no target request.
- R4: Acceptance is seen at the clock edge where `irq_pend` is high. After that edge `commit` is high for exactly one cycle, and it acts as the clear of the pending request. `exc_code` then holds bit 31 = 1 (asynchronous), bit 30 = 1 (controller interrupt), and the 22-bit code in bits [21:0], with zeros elsewhere.
- R5: `cause_val` holds the identifier in [11:0], the prior level in [23:16], the prior enable in bit 27 and `st_mpp` in [29:28], with zeros in [15:12], [26:24] and [30].
- R6: For a machine target, the prior level comes from `lvl_m` and the prior enable from `st_mie`. `wr_m` is high and `wr_s` is low.
- R7: For a supervisor target, the prior level comes from `lvl_s` and the prior enable from `st_spie`. `wr_s` is high and `wr_m` is low.
- R8: Bit XLEN-1 of `cause_val` is 1 on every commit.
- R9: On commit, `epc_val` equals the `pc` sampled at the accepting edge, and `new_priv` equals the target mode.
- R10: `tgt_req` rises together with `commit` and stays high until the edge where `tgt_ack` is sampled high. While it is high, no pending interrupt is accepted, and an interrupt still pending after the acknowledgement is accepted at the next edge.
- R11: After reset, `commit`, `wr_m`, `wr_s` and `tgt_req` are low, and all value outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | 1 | Controller has an interrupt pending |
| irq_code | input | 22 | Packed level, mode and identifier |
| cur_priv | input | 2 | Current privilege of the hart |
| st_mie | input | 1 | Machine interrupt enable |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor prior interrupt enable |
| st_mpp | input | 2 | Machine prior privilege field |
| lvl_m | input | 8 | Current machine interrupt level |
| lvl_s | input | 8 | Current supervisor interrupt level |
| pc | input | XLEN | PC of the interrupted instruction |
| tgt_ack | input | 1 | Vector stage has taken the target request |
| commit | output | 1 | One-cycle write-back strobe; clears the pending request |
| wr_m | output | 1 | Write-back goes to the machine-mode registers |
| wr_s | output | 1 | Write-back goes to the supervisor-mode registers |
| exc_code | output | 32 | Tagged internal exception code |
| cause_val | output | XLEN | New cause register value |
| epc_val | output | XLEN | New exception PC value |
| lvl_val | output | 8 | New level for the target mode's level field |
| new_priv | output | 2 | Privilege to switch to |
| tgt_req | output | 1 | Request to compute the trap target |
| tgt_mode | output | 2 | Target mode for the vector stage |
| tgt_id | output | 12 | Identifier for the vector stage |

## Verification
The hardest case to reach from the ports is a second interrupt that arrives while the first trap target is still outstanding. It must be held off for as long as the acknowledgement is withheld, and taken on the very next edge once it arrives. The bench keeps `tgt_ack` low for several cycles while a new code with different fields stays pending, and confirms that no commit appears. It then acknowledges, and checks that the commit lands exactly two edges later and carries the second code's fields. The acceptance rules are swept over every combination of current privilege and enable, for each target mode.

// File: rtl/clic_trap_pkg.sv
package clic_trap_pkg;

  localparam int ID_W        = 12;
  localparam int LVL_W       = 8;
  localparam int MODE_W      = 2;
  localparam int MODE_LSB    = ID_W;
  localparam int LVL_LSB     = MODE_LSB + MODE_W;
  localparam int CODE_W      = LVL_LSB + LVL_W;
  localparam int PLVL_LSB    = 16;
  localparam int PIE_BIT     = 27;
  localparam int PPRIV_LSB   = 28;
  localparam int CAUSE_LOW_W = 30;
  localparam int EXC_W       = 32;
  localparam int EXC_ASYNC   = 31;
  localparam int EXC_CTRL    = 30;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    priv_e            mode;
    logic [ID_W-1:0]  id;
  } irq_fields_t;

  // Can the hart take an interrupt aimed at mode tgt right now?
  function automatic logic f_mode_open(priv_e tgt, priv_e cur,
                                       logic mie, logic sie);
    logic ok;
    case (tgt)
      PRIV_M:  ok = (cur != PRIV_M) || mie;
      PRIV_S:  ok = (cur == PRIV_U) || ((cur == PRIV_S) && sie);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Low part of the cause word; the MSB is added by the caller.
  function automatic logic [CAUSE_LOW_W-1:0] f_cause_low(
      logic [ID_W-1:0] id, logic [LVL_W-1:0] plvl,
      logic pie, logic [1:0] ppriv);
    logic [CAUSE_LOW_W-1:0] c;
    c = '0;
    c[ID_W-1:0]                = id;
    c[PLVL_LSB +: LVL_W]       = plvl;
    c[PIE_BIT]                 = pie;
    c[PPRIV_LSB +: 2]          = ppriv;
    return c;
  endfunction

  // Internal exception code: asynchronous and controller tags on top of the code.
  function automatic logic [EXC_W-1:0] f_exc_tag(logic [CODE_W-1:0] code);
    logic [EXC_W-1:0] e;
    e = '0;
    e[CODE_W-1:0] = code;
    e[EXC_ASYNC]  = 1'b1;
    e[EXC_CTRL]   = 1'b1;
    return e;
  endfunction

endpackage

// File: rtl/irq_code_decode.sv
module irq_code_decode
  import clic_trap_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output priv_e             mode,
  output logic [LVL_W-1:0]  lvl,
  output logic [ID_W-1:0]   id
);
  irq_fields_t f;

  always_comb begin
    f    = irq_fields_t'(code);
    mode = f.mode;
    lvl  = f.lvl;
    id   = f.id;
  end
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import clic_trap_pkg::*;
(
  input  logic  pend,
  input  logic  busy,
  input  priv_e tgt,
  input  priv_e cur,
  input  logic  mie,
  input  logic  sie,
  output logic  mode_open,
  output logic  accept
);
  always_comb begin
    mode_open = f_mode_open(tgt, cur, mie, sie);
    accept    = pend && !busy && mode_open;
  end
endmodule

// File: rtl/cause_composer.sv
module cause_composer
  import clic_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  priv_e             tgt,
  input  logic [ID_W-1:0]   id,
  input  logic [LVL_W-1:0]  lvl_m,
  input  logic [LVL_W-1:0]  lvl_s,
  input  logic              mie,
  input  logic              spie,
  input  logic [1:0]        mpp,
  output logic [LVL_W-1:0]  prev_lvl,
  output logic              prev_ie,
  output logic [XLEN-1:0]   cause
);
  localparam int HI_W = XLEN - CAUSE_LOW_W;

  always_comb begin
    if (tgt == PRIV_S) begin
      prev_lvl = lvl_s;
      prev_ie  = spie;
    end else begin
      prev_lvl = lvl_m;
      prev_ie  = mie;
    end
  end

  generate
    if (HI_W > 1) begin : g_wide
      always_comb begin
        cause                    = '0;
        cause[CAUSE_LOW_W-1:0]   = f_cause_low(id, prev_lvl, prev_ie, mpp);
        cause[XLEN-1]            = 1'b1;
      end
    end else begin : g_narrow
      always_comb begin
        cause                    = '0;
        cause[CAUSE_LOW_W-1:0]   = f_cause_low(id, prev_lvl, prev_ie, mpp);
        cause[XLEN-1]            = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/clic_trap_entry.sv
module clic_trap_entry
  import clic_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     irq_pend,
  input  logic [CODE_W-1:0]        irq_code,
  input  logic [1:0]               cur_priv,
  input  logic                     st_mie,
  input  logic                     st_sie,
  input  logic                     st_spie,
  input  logic [1:0]               st_mpp,
  input  logic [LVL_W-1:0]         lvl_m,
  input  logic [LVL_W-1:0]         lvl_s,
  input  logic [XLEN-1:0]          pc,
  input  logic                     tgt_ack,
  output logic                     commit,
  output logic                     wr_m,
  output logic                     wr_s,
  output logic [EXC_W-1:0]         exc_code,
  output logic [XLEN-1:0]          cause_val,
  output logic [XLEN-1:0]          epc_val,
  output logic [LVL_W-1:0]         lvl_val,
  output logic [1:0]               new_priv,
  output logic                     tgt_req,
  output logic [1:0]               tgt_mode,
  output logic [ID_W-1:0]          tgt_id
);
  // Named internal events, visible to the bound checker.
  priv_e             dec_mode;
  logic [LVL_W-1:0]  dec_lvl;
  logic [ID_W-1:0]   dec_id;
  logic              mode_open;
  logic              accept;
  logic              busy;
  logic [LVL_W-1:0]  prev_lvl;
  logic              prev_ie;
  logic [XLEN-1:0]   cause_nxt;

  assign busy = tgt_req;

  irq_code_decode u_dec (
    .code (irq_code),
    .mode (dec_mode),
    .lvl  (dec_lvl),
    .id   (dec_id)
  );

  irq_accept_gate u_gate (
    .pend      (irq_pend),
    .busy      (busy),
    .tgt       (dec_mode),
    .cur       (priv_e'(cur_priv)),
    .mie       (st_mie),
    .sie       (st_sie),
    .mode_open (mode_open),
    .accept    (accept)
  );

  cause_composer #(.XLEN(XLEN)) u_cause (
    .tgt      (dec_mode),
    .id       (dec_id),
    .lvl_m    (lvl_m),
    .lvl_s    (lvl_s),
    .mie      (st_mie),
    .spie     (st_spie),
    .mpp      (st_mpp),
    .prev_lvl (prev_lvl),
    .prev_ie  (prev_ie),
    .cause    (cause_nxt)
  );

  // Single-cycle commit of every write-back for one accepted interrupt.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit    <= 1'b0;
      wr_m      <= 1'b0;
      wr_s      <= 1'b0;
      exc_code  <= '0;
      cause_val <= '0;
      epc_val   <= '0;
      lvl_val   <= '0;
      new_priv  <= 2'd0;
    end else begin
      commit <= accept;
      wr_m   <= accept && (dec_mode == PRIV_M);
      wr_s   <= accept && (dec_mode == PRIV_S);
      if (accept) begin
        exc_code  <= f_exc_tag(irq_code);
        cause_val <= cause_nxt;
        epc_val   <= pc;
        lvl_val   <= dec_lvl;
        new_priv  <= dec_mode;
      end
    end
  end

  // Trap-target request, held until acknowledged; blocks new acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_req  <= 1'b0;
      tgt_mode <= 2'd0;
      tgt_id   <= '0;
    end else if (accept) begin
      tgt_req  <= 1'b1;
      tgt_mode <= dec_mode;
      tgt_id   <= dec_id;
    end else if (tgt_req && tgt_ack) begin
      tgt_req  <= 1'b0;
    end
  end
endmodule

// File: rtl/clic_trap_entry_chk.sv
module clic_trap_entry_chk
  import clic_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_pend,
  input logic [CODE_W-1:0]   irq_code,
  input logic [1:0]          cur_priv,
  input logic                st_mie,
  input logic                st_sie,
  input logic [XLEN-1:0]     pc,
  input logic                tgt_ack,
  input logic                commit,
  input logic                wr_m,
  input logic                wr_s,
  input logic [EXC_W-1:0]    exc_code,
  input logic [XLEN-1:0]     cause_val,
  input logic [XLEN-1:0]     epc_val,
  input logic [LVL_W-1:0]    lvl_val,
  input logic [1:0]          new_priv,
  input logic                tgt_req,
  input logic                accept
);
  p_level_from_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> lvl_val == $past(irq_code[CODE_W-1:LVL_LSB]));

  p_machine_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && new_priv == 2'd3) |-> ($past(cur_priv) != 2'd3 || $past(st_mie)));

  p_super_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && new_priv == 2'd1) |->
      ($past(cur_priv) == 2'd0 || ($past(cur_priv) == 2'd1 && $past(st_sie))));

  p_no_odd_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (new_priv == 2'd1 || new_priv == 2'd3));

  p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_exc_tags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> exc_code[31:30] == 2'b11);

  p_machine_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_m |-> (commit && new_priv == 2'd3));

  p_super_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s |-> (commit && new_priv == 2'd1));

  p_one_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_m, wr_s}) && (commit == (wr_m || wr_s)));

  p_cause_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cause_val[XLEN-1]);

  p_epc_is_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> epc_val == $past(pc));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_ack) |=> tgt_req);

  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_ack) |=> !commit);

  p_req_with_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> tgt_req);

  p_accept_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> irq_pend);
endmodule

bind clic_trap_entry clic_trap_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_clic_trap_entry.sv
module tb_clic_trap_entry;
  localparam int XLEN = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             irq_pend;
  logic [21:0]      irq_code;
  logic [1:0]       cur_priv;
  logic             st_mie, st_sie, st_spie;
  logic [1:0]       st_mpp;
  logic [7:0]       lvl_m, lvl_s;
  logic [XLEN-1:0]  pc;
  logic             tgt_ack;
  logic             commit, wr_m, wr_s, tgt_req;
  logic [31:0]      exc_code;
  logic [XLEN-1:0]  cause_val, epc_val;
  logic [7:0]       lvl_val;
  logic [1:0]       new_priv, tgt_mode;
  logic [11:0]      tgt_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clic_trap_entry #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_code(irq_code),
    .cur_priv(cur_priv), .st_mie(st_mie), .st_sie(st_sie), .st_spie(st_spie),
    .st_mpp(st_mpp), .lvl_m(lvl_m), .lvl_s(lvl_s), .pc(pc), .tgt_ack(tgt_ack),
    .commit(commit), .wr_m(wr_m), .wr_s(wr_s), .exc_code(exc_code),
    .cause_val(cause_val), .epc_val(epc_val), .lvl_val(lvl_val),
    .new_priv(new_priv), .tgt_req(tgt_req), .tgt_mode(tgt_mode), .tgt_id(tgt_id)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] mk(input logic [1:0] m, input logic [7:0] l,
                                     input logic [11:0] id);
    return {l, m, id};
  endfunction

  // Expected acceptance, written from R2/R3.
  function automatic bit exp_take(input logic [1:0] m, input logic [1:0] p,
                                  input logic mie, input logic sie);
    if (m == 2'd3) return (p <= 2'd2) || mie;
    if (m == 2'd1) return (p == 2'd0) || (p == 2'd1 && sie);
    return 1'b0;
  endfunction

  task automatic set_ctx(input logic [1:0] p, input logic mie, input logic sie,
                         input logic spie, input logic [1:0] mpp,
                         input logic [7:0] lm, input logic [7:0] ls,
                         input logic [31:0] pcv);
    cur_priv = p; st_mie = mie; st_sie = sie; st_spie = spie; st_mpp = mpp;
    lvl_m = lm; lvl_s = ls; pc = pcv;
  endtask

  task automatic finish_req();
    @(negedge clk);
    chk(tgt_req == 1'b1, "R10 request held", tgt_req, 1);
    chk(commit == 1'b0, "R4 single commit", commit, 0);
    tgt_ack = 1'b1;
    @(negedge clk);
    tgt_ack = 1'b0;
    chk(tgt_req == 1'b0, "R10 request dropped on ack", tgt_req, 0);
  endtask

  // One offer of an interrupt; checks acceptance and, if taken, every write-back.
  task automatic offer(input logic [21:0] code, input string tag);
    bit take;
    logic [1:0] m;
    logic [7:0] pl;
    logic pie;
    logic [31:0] ec;
    logic [31:0] pcs;
    m = code[13:12];
    take = exp_take(m, cur_priv, st_mie, st_sie);
    pl  = (m == 2'd1) ? lvl_s : lvl_m;
    pie = (m == 2'd1) ? st_spie : st_mie;
    ec  = {1'b1, 1'b1, 8'h00, code};
    pcs = pc;
    @(negedge clk);
    irq_pend = 1'b1; irq_code = code;
    @(posedge clk); #1;
    if (take) begin
      chk(commit == 1'b1, {tag, " R2/R3 accept: R2 R3"}, commit, 1);
      chk(tgt_id == code[11:0] && tgt_mode == m && lvl_val == code[21:14],
          {tag, " R1 fields"}, {tgt_mode, tgt_id, lvl_val}, {m, code[11:0], code[21:14]});
      chk(exc_code == ec, {tag, " R4 exc code"}, exc_code, ec);
      chk(cause_val == {1'b1, 1'b0, st_mpp, pie, 3'b000, pl, 4'b0000, code[11:0]},
          {tag, " R5 R8 cause"}, cause_val,
          {1'b1, 1'b0, st_mpp, pie, 3'b000, pl, 4'b0000, code[11:0]});
      if (m == 2'd3)
        chk(wr_m && !wr_s, {tag, " R6 machine dest"}, {wr_m, wr_s}, 2'b10);
      else
        chk(wr_s && !wr_m, {tag, " R7 super dest"}, {wr_m, wr_s}, 2'b01);
      chk(epc_val == pcs && new_priv == m, {tag, " R9 epc/priv"},
          {epc_val, new_priv}, {pcs, m});
      @(negedge clk);
      irq_pend = 1'b0;
      chk(tgt_req == 1'b1, {tag, " R10 request raised"}, tgt_req, 1);
      finish_req();
    end else begin
      chk(commit == 1'b0 && tgt_req == 1'b0, {tag, " R3 rejected"},
          {commit, tgt_req}, 0);
      @(posedge clk); #1;
      chk(commit == 1'b0 && tgt_req == 1'b0, {tag, " R3 still rejected"},
          {commit, tgt_req}, 0);
      @(negedge clk);
      irq_pend = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; irq_pend = 1'b0; irq_code = '0; tgt_ack = 1'b0;
    set_ctx(2'd0, 0, 0, 0, 2'd0, 8'h00, 8'h00, 32'h0);
    repeat (3) @(posedge clk);
    #1;
    chk(!commit && !wr_m && !wr_s && !tgt_req, "R11 reset strobes",
        {commit, wr_m, wr_s, tgt_req}, 0);
    chk(cause_val == 0 && epc_val == 0 && exc_code == 0 && lvl_val == 0 &&
        new_priv == 0 && tgt_id == 0 && tgt_mode == 0, "R11 reset values",
        cause_val, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_machine_cases();
    set_ctx(2'd0, 0, 0, 1, 2'd3, 8'h12, 8'h34, 32'h8000_0100);
    offer(mk(2'd3, 8'hA5, 12'h123), "M from U");
    set_ctx(2'd1, 0, 0, 0, 2'd1, 8'hFF, 8'h01, 32'h8000_0200);
    offer(mk(2'd3, 8'h00, 12'hFFF), "M from S");
    set_ctx(2'd3, 1, 0, 0, 2'd2, 8'h7E, 8'h00, 32'hDEAD_BEE0);
    offer(mk(2'd3, 8'hFF, 12'h001), "M from M mie");
    set_ctx(2'd3, 0, 1, 1, 2'd3, 8'h10, 8'h20, 32'h0000_0040);
    offer(mk(2'd3, 8'h80, 12'h055), "M from M masked");
  endtask

  task automatic t_super_cases();
    set_ctx(2'd0, 1, 0, 1, 2'd1, 8'h44, 8'h9C, 32'h1234_5678);
    offer(mk(2'd1, 8'h3C, 12'hABC), "S from U");
    set_ctx(2'd1, 0, 1, 0, 2'd0, 8'h01, 8'hC3, 32'h0000_1000);
    offer(mk(2'd1, 8'h81, 12'h800), "S from S sie");
    set_ctx(2'd1, 1, 0, 1, 2'd0, 8'h01, 8'hC3, 32'h0000_1004);
    offer(mk(2'd1, 8'h81, 12'h800), "S from S masked");
    set_ctx(2'd3, 1, 1, 1, 2'd0, 8'h01, 8'hC3, 32'h0000_1008);
    offer(mk(2'd1, 8'h81, 12'h800), "S from M");
  endtask

  task automatic t_odd_modes();
    set_ctx(2'd0, 1, 1, 1, 2'd0, 8'h00, 8'h00, 32'h0);
    offer(mk(2'd0, 8'h11, 12'h010), "mode U");
    offer(mk(2'd2, 8'h11, 12'h010), "mode 2");
  endtask

  // Full sweep of the acceptance rules (R2, R3).
  task automatic t_sweep();
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++)
        for (int e = 0; e < 4; e++) begin
          set_ctx(p[1:0], e[0], e[1], e[0], 2'd1, 8'h5A, 8'hA5, 32'h100 + 32'(p*16+e));
          offer(mk(m[1:0], 8'(m*16+p), 12'(m*64+e)), "sweep R2 R3");
        end
  endtask

  // Second interrupt held off while the target request is outstanding (R10).
  task automatic t_busy();
    set_ctx(2'd0, 0, 0, 0, 2'd2, 8'h01, 8'h02, 32'h0000_2000);
    @(negedge clk);
    irq_pend = 1'b1; irq_code = mk(2'd3, 8'h40, 12'h111);
    @(posedge clk); #1;
    chk(commit == 1'b1, "R10 first accept", commit, 1);
    @(negedge clk);
    irq_code = mk(2'd1, 8'h66, 12'h222);
    pc = 32'h0000_3000;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(commit == 1'b0 && tgt_req == 1'b1, "R10 held off while busy",
          {commit, tgt_req}, 1);
    end
    @(negedge clk);
    tgt_ack = 1'b1;
    @(posedge clk); #1;
    chk(commit == 1'b0 && tgt_req == 1'b0, "R10 ack edge no commit",
        {commit, tgt_req}, 0);
    @(negedge clk);
    tgt_ack = 1'b0;
    @(posedge clk); #1;
    chk(commit == 1'b1 && wr_s && tgt_id == 12'h222 && lvl_val == 8'h66 &&
        epc_val == 32'h0000_3000, "R10 second accept after ack",
        {commit, wr_s, tgt_id, lvl_val}, {1'b1, 1'b1, 12'h222, 8'h66});
    chk(cause_val == {1'b1, 1'b0, 2'd2, 1'b0, 3'b000, 8'h02, 4'b0000, 12'h222},
        "R7 prior supervisor level", cause_val,
        {1'b1, 1'b0, 2'd2, 1'b0, 3'b000, 8'h02, 4'b0000, 12'h222});
    @(negedge clk);
    irq_pend = 1'b0;
    finish_req();
  endtask

  initial begin
    t_reset();
    t_machine_cases();
    t_super_cases();
    t_odd_modes();
    t_busy();
    t_sweep();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule